// File: doc/BRIEF.md
# Run-Time Reconfigurable Shift-Register Sequence Generator

This block is a WIDTH-bit linear feedback shift register whose tap coefficients and feedback topology can both be changed while it runs. A single mode pin picks between a single-XOR-tree external feedback (Fibonacci) and a distributed internal feedback (Galois). A polynomial strobe latches a coefficient vector. A seed strobe preloads the register. With a primitive characteristic polynomial and a nonzero seed, either topology walks through every nonzero state before it repeats.

The block serves as a pattern source for built-in self-test or as a keystream core. Software or a test controller first latches the coefficients and the seed. It then raises the enable and reads the state vector on every cycle. Bit j of the coefficient vector (Cj) is the coefficient of x^j in p(x) = x^WIDTH + C(WIDTH-1)x^(WIDTH-1) + ... + C1x + C0. The leading term is implied.

Top module: `rlfsr_core`

## Requirements
- R1: A synchronous reset clears both the state and the stored coefficient vector to all zeros. A reset wins over every other input in the same cycle.
- R2: When enable is low and no strobe is high, the state holds. Values on the seed and polynomial inputs have no effect.
- R3: When seed_ld is high, the state takes seed_i at the next clock edge. That cycle does not also shift.
- R4: When poly_ld is high and seed_ld is low, the coefficient vector takes poly_i at the next edge. The state is unchanged in that cycle.
- R5: When seed_ld and poly_ld are both high, only the seed is taken and the coefficient vector keeps its old value.
- R6: In external mode (mode_i = 0), one enabled step computes f = XOR over j of (Cj AND s[j]). The step then moves every bit down one place (s[j] <= s[j+1]) and puts f into bit WIDTH-1.
- R7: In internal mode (mode_i = 1), one enabled step sends the outgoing bit s[0] into bit WIDTH-1. For every j < WIDTH-1, it sets s[j] <= s[j+1] XOR (s[0] AND C(j+1)). C0 has no effect in this mode.
- R8: The mode pin is sampled on each step. Changing it between steps alters neither the state nor the coefficients until the next step.
- R9: At WIDTH = 4, the coefficients 0011 (p = x^4 + x + 1) with seed 0010 return to the seed after exactly 15 steps in each mode.
- R10: At WIDTH = 8, the coefficients 0x71 (p = x^8 + x^6 + x^5 + x^4 + 1) with seed 0x91 return to the seed after exactly 255 steps in each mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step enable |
| mode_i | input | 1 | Feedback topology: 0 external, 1 internal |
| seed_i | input | WIDTH | Seed value |
| seed_ld | input | 1 | Seed load strobe |
| poly_i | input | WIDTH | Coefficient vector, bit j is Cj |
| poly_ld | input | 1 | Coefficient load strobe |
| state_o | output | WIDTH | Current register state |

## Verification
The coefficient register has no output of its own, so its contents can only be seen through the steps that follow a load. The stimulus table therefore runs steps after every event that might disturb the coefficients: the reset, the simultaneous double strobe, and a C0-only change in internal mode. A stored value that differs then shows up as a wrong state a few cycles later. Whole-period runs at two widths confirm that each topology really realises the loaded polynomial rather than some other one.

// File: rtl/rlfsr_pkg.sv
package rlfsr_pkg;

  typedef enum logic {
    FB_EXTERNAL = 1'b0,
    FB_INTERNAL = 1'b1
  } fb_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SEED = 2'd1,
    ACT_POLY = 2'd2,
    ACT_STEP = 2'd3
  } act_e;

  // One action per cycle: seed load beats polynomial load beats a step.
  function automatic act_e pick_action(input logic seed_ld, input logic poly_ld,
                                       input logic en);
    if (seed_ld)      return ACT_SEED;
    else if (poly_ld) return ACT_POLY;
    else if (en)      return ACT_STEP;
    else              return ACT_NONE;
  endfunction

endpackage

// File: rtl/rlfsr_coef_reg.sv
module rlfsr_coef_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/rlfsr_feedback.sv
module rlfsr_feedback #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]     state,
  input  logic [WIDTH-1:0]     coef,
  input  rlfsr_pkg::fb_mode_e  mode,
  output logic [WIDTH-1:0]     nxt,
  output logic                 ext_bit,
  output logic                 out_bit
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] tap_and;
  logic [WIDTH-1:0] ext_nxt;
  logic [WIDTH-1:0] int_nxt;

  assign out_bit = state[0];

  genvar j;
  generate
    for (j = 0; j < WIDTH; j++) begin : g_tap
      assign tap_and[j] = state[j] & coef[j];
    end
    for (j = 0; j < LAST; j++) begin : g_stage
      assign ext_nxt[j] = state[j+1];
      assign int_nxt[j] = state[j+1] ^ (out_bit & coef[j+1]);
    end
  endgenerate

  assign ext_bit       = ^tap_and;
  assign ext_nxt[LAST] = ext_bit;
  assign int_nxt[LAST] = out_bit;

  always_comb begin
    case (mode)
      rlfsr_pkg::FB_INTERNAL: nxt = int_nxt;
      default:                nxt = ext_nxt;
    endcase
  end
endmodule

// File: rtl/rlfsr_state_reg.sv
module rlfsr_state_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] seed,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] d;

  genvar j;
  generate
    for (j = 0; j < WIDTH; j++) begin : g_flop
      // per-flop selector: seed, feedback or hold
      assign d[j] = load ? seed[j] : (step ? nxt[j] : q[j]);
      always_ff @(posedge clk) begin
        if (rst) q[j] <= 1'b0;
        else     q[j] <= d[j];
      end
    end
  endgenerate
endmodule

// File: rtl/rlfsr_core.sv
module rlfsr_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             seed_ld,
  input  logic [WIDTH-1:0] poly_i,
  input  logic             poly_ld,
  output logic [WIDTH-1:0] state_o
);
  rlfsr_pkg::act_e     act;
  rlfsr_pkg::fb_mode_e mode_e;
  logic                ev_seed;
  logic                ev_poly;
  logic                ev_step;
  logic [WIDTH-1:0]    coef_q;
  logic [WIDTH-1:0]    state_q;
  logic [WIDTH-1:0]    step_val;
  logic                ext_bit;
  logic                out_bit;

  assign act     = rlfsr_pkg::pick_action(seed_ld, poly_ld, en);
  assign ev_seed = (act == rlfsr_pkg::ACT_SEED);
  assign ev_poly = (act == rlfsr_pkg::ACT_POLY);
  assign ev_step = (act == rlfsr_pkg::ACT_STEP);
  assign mode_e  = rlfsr_pkg::fb_mode_e'(mode_i);

  rlfsr_coef_reg #(.WIDTH(WIDTH)) u_coef (
    .clk  (clk),
    .rst  (rst),
    .load (ev_poly),
    .d    (poly_i),
    .q    (coef_q)
  );

  rlfsr_feedback #(.WIDTH(WIDTH)) u_fb (
    .state   (state_q),
    .coef    (coef_q),
    .mode    (mode_e),
    .nxt     (step_val),
    .ext_bit (ext_bit),
    .out_bit (out_bit)
  );

  rlfsr_state_reg #(.WIDTH(WIDTH)) u_state (
    .clk  (clk),
    .rst  (rst),
    .load (ev_seed),
    .step (ev_step),
    .seed (seed_i),
    .nxt  (step_val),
    .q    (state_q)
  );

  assign state_o = state_q;
endmodule

// File: rtl/rlfsr_core_chk.sv
module rlfsr_core_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             mode_i,
  input logic [WIDTH-1:0] seed_i,
  input logic             seed_ld,
  input logic             poly_ld,
  input logic [WIDTH-1:0] poly_i,
  input logic [WIDTH-1:0] state_o,
  input logic [WIDTH-1:0] coef_q,
  input logic             ev_step
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (state_o == '0 && coef_q == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!en && !seed_ld && !poly_ld) |=> $stable(state_o));

  p_seed_take_r3: assert property (@(posedge clk) disable iff (rst)
    seed_ld |=> (state_o == $past(seed_i)));

  p_poly_take_r4: assert property (@(posedge clk) disable iff (rst)
    (poly_ld && !seed_ld) |=> (coef_q == $past(poly_i) && $stable(state_o)));

  p_seed_first_r5: assert property (@(posedge clk) disable iff (rst)
    (seed_ld && poly_ld) |=> $stable(coef_q));

  p_ext_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_step && !mode_i) |=> (state_o[WIDTH-2:0] == $past(state_o[WIDTH-1:1])));

  p_int_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_step && mode_i) |=> (state_o[WIDTH-1] == $past(state_o[0])));
endmodule

bind rlfsr_core rlfsr_core_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .mode_i  (mode_i),
  .seed_i  (seed_i),
  .seed_ld (seed_ld),
  .poly_ld (poly_ld),
  .poly_i  (poly_i),
  .state_o (state_o),
  .coef_q  (coef_q),
  .ev_step (ev_step)
);

// File: tb/rlfsr_core_bench.sv
module rlfsr_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       mode = 1'b0;
  logic [7:0] seed = '0;
  logic       sld = 1'b0;
  logic [7:0] poly = '0;
  logic       pld = 1'b0;
  logic [7:0] st8;

  logic       en4 = 1'b0;
  logic [3:0] seed4 = '0;
  logic       sld4 = 1'b0;
  logic [3:0] poly4 = '0;
  logic       pld4 = 1'b0;
  logic [3:0] st4;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rlfsr_core #(.WIDTH(8)) u_rlfsr_core (
    .clk(clk), .rst(rst), .en(en), .mode_i(mode), .seed_i(seed), .seed_ld(sld),
    .poly_i(poly), .poly_ld(pld), .state_o(st8));

  rlfsr_core #(.WIDTH(4)) u_rlfsr_core_w4 (
    .clk(clk), .rst(rst), .en(en4), .mode_i(mode), .seed_i(seed4), .seed_ld(sld4),
    .poly_i(poly4), .poly_ld(pld4), .state_o(st4));

  localparam logic [2:0] OP_RST = 3'd0, OP_SEED = 3'd1, OP_POLY = 3'd2,
                         OP_STEP = 3'd3, OP_IDLE = 3'd4, OP_BOTH = 3'd5;
  localparam int NV = 27;
  // {op, mode, data}
  localparam logic [11:0] VEC [NV] = '{
    {OP_RST,  1'b0, 8'h00}, {OP_SEED, 1'b0, 8'hFF}, {OP_STEP, 1'b0, 8'h00},
    {OP_STEP, 1'b1, 8'hAA}, {OP_POLY, 1'b0, 8'h71}, {OP_SEED, 1'b0, 8'h91},
    {OP_STEP, 1'b0, 8'h5A}, {OP_STEP, 1'b0, 8'h00}, {OP_STEP, 1'b0, 8'hFF},
    {OP_IDLE, 1'b0, 8'hC3}, {OP_IDLE, 1'b1, 8'h3C}, {OP_STEP, 1'b0, 8'h00},
    {OP_BOTH, 1'b0, 8'h3C}, {OP_STEP, 1'b0, 8'h00}, {OP_STEP, 1'b1, 8'h00},
    {OP_STEP, 1'b1, 8'h00}, {OP_STEP, 1'b0, 8'h00}, {OP_SEED, 1'b1, 8'h91},
    {OP_STEP, 1'b1, 8'h00}, {OP_STEP, 1'b1, 8'h00}, {OP_STEP, 1'b1, 8'h00},
    {OP_POLY, 1'b1, 8'h70}, {OP_SEED, 1'b1, 8'h91}, {OP_STEP, 1'b1, 8'h00},
    {OP_STEP, 1'b1, 8'h00}, {OP_STEP, 1'b1, 8'h00}, {OP_RST,  1'b1, 8'h55}
  };

  // reference: recurrence form of the external topology
  function automatic logic [7:0] ref_ext(input logic [7:0] s, input logic [7:0] c);
    logic b = 1'b0;
    for (int k = 0; k < 8; k++) b = b ^ (s[k] & c[k]);
    return (s >> 1) | ({7'd0, b} << 7);
  endfunction

  // reference: divide by x modulo p (internal topology), C0 implied
  function automatic logic [7:0] ref_int(input logic [7:0] s, input logic [7:0] c);
    logic [7:0] r = s >> 1;
    if (s[0]) r = r ^ ((c >> 1) | 8'h80);
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic md);
    case (op)
      OP_RST:  return "R1";
      OP_SEED: return "R3";
      OP_POLY: return "R4";
      OP_IDLE: return "R2";
      OP_BOTH: return "R5";
      default: return md ? "R7 R8" : "R6 R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    logic [7:0] ms;
    logic [7:0] mc;
    int first;
    ms = '0;
    mc = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", st8, 8'h00);

    // table walk; R1 coefficients cleared is seen in the step after the reseed
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic       md;
      logic [7:0] dv;
      op = VEC[i][11:9];
      md = VEC[i][8];
      dv = VEC[i][7:0];
      rst  = (op == OP_RST);
      mode = md;
      seed = dv;
      poly = dv;
      sld  = (op == OP_SEED) || (op == OP_BOTH);
      pld  = (op == OP_POLY) || (op == OP_BOTH);
      en   = (op != OP_IDLE);
      @(negedge clk);
      case (op)
        OP_RST:  begin ms = '0; mc = '0; end
        OP_SEED, OP_BOTH: ms = dv;
        OP_POLY: mc = dv;
        OP_STEP: ms = md ? ref_int(ms, mc) : ref_ext(ms, mc);
        default: ;
      endcase
      chk(tag_of(op, md), st8, ms);
    end
    rst = 1'b0; sld = 1'b0; pld = 1'b0; en = 1'b0;

    // R9: 4-bit period 15 in both modes
    for (int m = 0; m < 2; m++) begin
      mode = m[0];
      poly4 = 4'b0011; pld4 = 1'b1;
      @(negedge clk);
      pld4 = 1'b0; seed4 = 4'b0010; sld4 = 1'b1;
      @(negedge clk);
      sld4 = 1'b0; en4 = 1'b1;
      first = 0;
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        if (first == 0 && st4 == 4'b0010) first = k;
      end
      en4 = 1'b0;
      chk(m ? "R9 internal" : "R9 external", first[7:0], 8'd15);
    end

    // R10: 8-bit period 255 in both modes
    for (int m = 0; m < 2; m++) begin
      mode = m[0];
      poly = 8'h71; pld = 1'b1;
      @(negedge clk);
      pld = 1'b0; seed = 8'h91; sld = 1'b1;
      @(negedge clk);
      sld = 1'b0; en = 1'b1;
      first = 0;
      for (int k = 1; k <= 260; k++) begin
        @(negedge clk);
        if (first == 0 && st8 == 8'h91) first = k;
      end
      en = 1'b0;
      chk(m ? "R10 internal" : "R10 external", first[7:0], 8'd255);
    end

    // R1: reset wins over a simultaneous seed strobe
    seed = 8'hA5; sld = 1'b1; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; sld = 1'b0;
    chk("R1 priority", st8, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule